// File: doc/BRIEF.md
# Sync Input Timing Margin Monitor

This block watches a sync line that arrives with no fixed phase relation to the converter clock. It raises a sticky error when the window in which the line is stable around the chosen sampling point becomes too narrow. A single fast clock stands in for the oversampling clock. It shifts the sync line into a tap chain, so each tap holds the line one oversampling period older than the tap before it. A delay select picks which tap is the sampling point. On each converter clock edge, marked by a one-cycle strobe, the block counts how many consecutive taps on each side of that point hold the same level. Older taps give the setup margin and newer taps give the hold margin.

If either margin is below a programmed threshold, the block records an error. This happens even when the sampled level itself is correct, and the block also records which side caused it. Software uses a manual sweep: clear the error, step the delay select, and read the error again until it stays clear. The block also outputs the sync sample taken at the chosen tap, updated on every strobe.

Top module: `sync_margin_mon`

## Requirements
- R1: After reset the config register reads 0, the status register reads 0, `irq` is 0 and `sync_out` is 0.
- R2: Config register (address 0) packs threshold in bits [3:0], delay select in [8:4], check mode in bit 9 and error enable in bit 10. A write to it is read back unchanged.
- R3: At a strobe edge, tap k holds the `sync_in` value captured k+1 edges earlier, and the sampling tap is c = delay+15. The setup margin is the count of consecutive taps c+1, c+2, ... (up to 15) that equal tap c. The hold margin counts taps c-1, c-2, ... (up to 15) the same way. An error is detected when either margin is below the threshold.
- R4: A threshold of 0 behaves as 1: an error is detected only if tap c differs from tap c+1 or from tap c-1.
- R5: Changing the delay select moves the sampling tap by the same number of taps.
- R6: Status bit 0 (address 1) is sticky once set. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R7: If an error is detected in the same cycle as a clearing write, the status bit ends up set.
- R8: Status bit 1 gives the kind of the most recent detected error: 0 for setup, 1 for hold. When both sides fail together it reads 0.
- R9: With the error enable at 0, no error is recorded and `irq` is 0. `irq` equals status bit 0 whenever the enable is 1.
- R10: With check mode at 1, detection is suspended and status bit 0 is not set. Mode 0 is the manual checking mode.
- R11: `sync_out` takes the level of tap c at each strobe edge and holds it between strobes.
- R12: Detection happens only at edges where `dac_strobe` is 1. Status and `sync_out` change at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | Sync line being monitored |
| dac_strobe | input | 1 | One-cycle marker of a converter clock edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 config, 1 status |
| wr_data | input | 11 | Write data |
| rd_addr | input | 1 | Read address: 0 config, 1 status |
| rd_data | output | 11 | Read data, combinational from the registers |
| sync_out | output | 1 | Realigned sync sample |
| irq | output | 1 | Error interrupt (status bit 0 gated by enable) |

## Verification
Two things can land on the same edge: a new margin error found at a strobe, and a software write of 1 that clears the sticky bit. The sweep drives a long run-length pattern with random strobes and random clearing writes, so both happen together many times over every delay and threshold. In those cycles the bench expects the status bit to read 1 and the error kind to reflect the new error. A lost detection in such a cycle would look like a successful clear, so these cycles are counted under their own requirement.

// File: rtl/sm_pkg.sv
// Package: shared constants and types for the sync margin monitor.
// Assumes: register addresses are one bit wide; field packing is derived
// from the widths in the modules that use it.
package sm_pkg;

    // Kind of the most recent margin error, as software reads it
    typedef enum logic {
        ERR_SETUP = 1'b0,
        ERR_HOLD  = 1'b1
    } err_kind_e;

    localparam logic ADDR_CFG  = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    localparam int STAT_ERR_BIT  = 0;
    localparam int STAT_KIND_BIT = 1;

endpackage

// File: rtl/sm_tap_chain.sv
// Module: sm_tap_chain
// Shifts the sync line into a chain of taps, one per oversampling clock.
// Tap 0 is the newest sample. Assumes sync_in has already been brought
// into the clk domain or that metastability is handled upstream.
module sm_tap_chain #(
    parameter int DEPTH = 62
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    output logic [DEPTH-1:0] taps
);

    // Shift one position per clock, newest value enters at tap 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps <= '0;
        end else begin
            taps <= {taps[DEPTH-2:0], sync_in};
        end
    end

    AST_TAP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (taps[1] == $past(taps[0]))); // R3

endmodule

// File: rtl/sm_margin_meas.sv
// Module: sm_margin_meas
// Picks the sampling tap from the delay select and counts the run of
// matching taps on each side of it (older side = setup, newer = hold),
// saturating at 2**THR_W-1, then compares each count with the threshold.
// Assumes DEPTH covers the widest delay plus the margin window on both sides.
module sm_margin_meas #(
    parameter int DEPTH = 62,
    parameter int DLY_W = 5,
    parameter int THR_W = 4
) (
    input  logic [DEPTH-1:0] taps,
    input  logic [DLY_W-1:0] dly_sel,
    input  logic [THR_W-1:0] thr,
    output logic             centre,
    output logic             setup_fail,
    output logic             hold_fail
);

    localparam int MMAX  = (1 << THR_W) - 1;
    localparam int WIN   = 2 * MMAX + 1;
    localparam int IDX_W = $clog2(DEPTH);

    logic [WIN-1:0]   win;
    logic [MMAX:1]    s_run;
    logic [MMAX:1]    h_run;
    logic [THR_W-1:0] s_margin;
    logic [THR_W-1:0] h_margin;
    logic [THR_W-1:0] eff_thr;

    // Window of taps centred on the selected sampling point
    for (genvar i = 0; i < WIN; i++) begin : g_win
        assign win[i] = taps[IDX_W'(dly_sel) + IDX_W'(i)];
    end

    assign centre = win[MMAX];

    // Prefix runs: bit k is set while taps 1..k away still match the centre
    for (genvar k = 1; k <= MMAX; k++) begin : g_run
        if (k == 1) begin : g_first
            assign s_run[k] = (win[MMAX + k] == centre);
            assign h_run[k] = (win[MMAX - k] == centre);
        end else begin : g_next
            assign s_run[k] = s_run[k-1] & (win[MMAX + k] == centre);
            assign h_run[k] = h_run[k-1] & (win[MMAX - k] == centre);
        end
    end

    // Count matching taps on each side and compare with the threshold
    always_comb begin
        s_margin   = THR_W'($countones(s_run));
        h_margin   = THR_W'($countones(h_run));
        eff_thr    = (thr == '0) ? THR_W'(1) : thr;
        setup_fail = (s_margin < eff_thr);
        hold_fail  = (h_margin < eff_thr);
    end

endmodule

// File: rtl/sm_ctrl_regs.sv
// Module: sm_ctrl_regs
// Holds the config register and the status register (sticky error with
// write-one-to-clear, plus the error kind). Latches a new error on strobe
// edges when enabled in manual mode, and holds the realigned sync sample.
// Assumes one write per cycle; a detection in the same cycle overrides a clear.
module sm_ctrl_regs
    import sm_pkg::*;
#(
    parameter int DLY_W  = 5,
    parameter int THR_W  = 4,
    parameter int DATA_W = THR_W + DLY_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              strobe,
    input  logic              centre,
    input  logic              setup_fail,
    input  logic              hold_fail,
    output logic [THR_W-1:0]  thr,
    output logic [DLY_W-1:0]  dly_sel,
    output logic              sync_out,
    output logic              irq
);

    localparam int DLY_LSB = THR_W;
    localparam int MODE_B  = THR_W + DLY_W;
    localparam int EN_B    = MODE_B + 1;

    logic      mode_auto;
    logic      err_en;
    logic      err_q;
    err_kind_e kind_q;
    logic      det;
    logic      clr;
    logic      cfg_wr;

    // Decode write strobes and the detection condition
    always_comb begin
        cfg_wr = wr_en && (wr_addr == ADDR_CFG);
        clr    = wr_en && (wr_addr == ADDR_STAT) && wr_data[STAT_ERR_BIT];
        det    = strobe && !mode_auto && err_en && (setup_fail || hold_fail);
    end

    // Config register: threshold, delay select, check mode, enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr       <= '0;
            dly_sel   <= '0;
            mode_auto <= 1'b0;
            err_en    <= 1'b0;
        end else if (cfg_wr) begin
            thr       <= wr_data[THR_W-1:0];
            dly_sel   <= wr_data[DLY_LSB +: DLY_W];
            mode_auto <= wr_data[MODE_B];
            err_en    <= wr_data[EN_B];
        end
    end

    // Sticky error bit: set by detection, cleared by a write of one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (det) begin
            err_q <= 1'b1;
        end else if (clr) begin
            err_q <= 1'b0;
        end
    end

    // Error kind: updated on every detection, setup wins a tie
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= ERR_SETUP;
        end else if (det) begin
            kind_q <= setup_fail ? ERR_SETUP : ERR_HOLD;
        end
    end

    // Realigned sync sample, refreshed on each converter edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_out <= 1'b0;
        end else if (strobe) begin
            sync_out <= centre;
        end
    end

    // Read mux and interrupt output
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_CFG) begin
            rd_data = {err_en, mode_auto, dly_sel, thr};
        end else begin
            rd_data[STAT_ERR_BIT]  = err_q;
            rd_data[STAT_KIND_BIT] = kind_q;
        end
        irq = err_q & err_en;
    end

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr) |=> err_q); // R6

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(strobe && (setup_fail || hold_fail))) |=> !err_q); // R6

    AST_SET_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && strobe && !mode_auto && err_en && (setup_fail || hold_fail)) |=> err_q); // R7

    AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !mode_auto && err_en && setup_fail && hold_fail) |=> (kind_q == ERR_SETUP)); // R8

    AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_en && !err_q) |=> !err_q); // R9

    AST_MODE_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_auto && !err_q) |=> !err_q); // R10

    AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(sync_out)); // R11

endmodule

// File: rtl/sync_margin_mon.sv
// Module: sync_margin_mon (top)
// Monitors setup and hold margin of an asynchronous sync line around a
// programmable sampling tap. The tap chain is clocked by clk (oversampling);
// dac_strobe marks the converter clock edges on which margins are judged.
// Assumes dac_strobe is synchronous to clk and at most one cycle wide.
module sync_margin_mon #(
    parameter int DLY_W  = 5,
    parameter int THR_W  = 4,
    parameter int DATA_W = THR_W + DLY_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_in,
    input  logic              dac_strobe,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              sync_out,
    output logic              irq
);

    localparam int MMAX  = (1 << THR_W) - 1;
    localparam int DEPTH = (1 << DLY_W) + 2 * MMAX;
    localparam int IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0] taps;
    logic [THR_W-1:0] thr;
    logic [DLY_W-1:0] dly_sel;
    logic             centre;
    logic             setup_fail;
    logic             hold_fail;
    logic [IDX_W-1:0] c_idx;

    sm_tap_chain #(
        .DEPTH (DEPTH)
    ) chain_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .taps    (taps)
    );

    sm_margin_meas #(
        .DEPTH (DEPTH),
        .DLY_W (DLY_W),
        .THR_W (THR_W)
    ) meas_i (
        .taps       (taps),
        .dly_sel    (dly_sel),
        .thr        (thr),
        .centre     (centre),
        .setup_fail (setup_fail),
        .hold_fail  (hold_fail)
    );

    sm_ctrl_regs #(
        .DLY_W  (DLY_W),
        .THR_W  (THR_W),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .strobe     (dac_strobe),
        .centre     (centre),
        .setup_fail (setup_fail),
        .hold_fail  (hold_fail),
        .thr        (thr),
        .dly_sel    (dly_sel),
        .sync_out   (sync_out),
        .irq        (irq)
    );

    // Sampling tap index, used only to guard the measurement below
    assign c_idx = IDX_W'(dly_sel) + IDX_W'(MMAX);

    AST_ZERO_THR: assert property (@(posedge clk) disable iff (!rst_n)
        ((thr == '0) && (taps[c_idx] == taps[c_idx + 1'b1]) && (taps[c_idx] == taps[c_idx - 1'b1]))
        |-> (!setup_fail && !hold_fail)); // R4

    AST_CENTRE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (centre == taps[c_idx])); // R5

endmodule

// File: tb/sync_margin_mon_tb.sv
// Bench: sweeps every delay select and threshold with a run-length sync
// pattern, random strobes and random clearing writes, and compares the
// ports against a model built from the requirements.
module sync_margin_mon_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW    = 11;
    localparam int MMAX  = 15;
    localparam int DEPTH = 62;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_in = 1'b0;
    logic          dac_strobe = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_addr = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_addr = 1'b1;
    logic [DW-1:0] rd_data;
    logic          sync_out;
    logic          irq;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // Model state
    bit hist [DEPTH];
    bit m_err, m_kind, m_sync;
    int m_thr, m_dly;
    bit m_mode, m_en;
    bit last_det, last_clr;
    int run_left = 0;
    bit level = 1'b0;

    sync_margin_mon dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_in    (sync_in),
        .dac_strobe (dac_strobe),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .sync_out   (sync_out),
        .irq        (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic void judge(output bit sf, output bit hf, output bit cen);
        int c = m_dly + MMAX;
        int s = 0;
        int h = 0;
        bit go_s = 1'b1;
        bit go_h = 1'b1;
        int eff = (m_thr == 0) ? 1 : m_thr;
        cen = hist[c];
        for (int k = 1; k <= MMAX; k++) begin
            if (go_s && hist[c+k] == cen) s++; else go_s = 1'b0;
            if (go_h && hist[c-k] == cen) h++; else go_h = 1'b0;
        end
        sf = (s < eff);
        hf = (h < eff);
    endfunction

    // One clock: drive at negedge, update the model just after posedge
    task automatic step(input bit s_in, input bit stb, input bit we, input bit wa, input logic [DW-1:0] wd);
        bit sf, hf, cen, det, clr;
        @(negedge clk);
        sync_in = s_in; dac_strobe = stb; wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk);
        #1;
        judge(sf, hf, cen);
        det = stb && !m_mode && m_en && (sf || hf);
        clr = we && wa && wd[0];
        if (we && !wa) begin
            m_thr = int'(wd[3:0]); m_dly = int'(wd[8:4]); m_mode = wd[9]; m_en = wd[10];
        end
        if (det) m_kind = sf ? 1'b0 : 1'b1;
        m_err = det | (m_err & ~clr);
        if (stb) m_sync = cen;
        for (int i = DEPTH-1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = s_in;
        last_det = det;
        last_clr = clr;
    endtask

    task automatic write_cfg(input int thr, input int dly, input bit mode, input bit en);
        step(level, 1'b0, 1'b1, 1'b0, {en, mode, 5'(dly), 4'(thr)});
    endtask

    // Compare status, kind, irq and sample against the model
    task automatic compare_all();
        string req;
        if (!m_en)                  req = "R9";
        else if (m_mode)            req = "R10";
        else if (last_det && last_clr) req = "R7";
        else if (m_thr == 0)        req = "R4";
        else                        req = "R3";
        chk(rd_data[0], m_err, {req, " R5 R12"});
        chk(rd_data[1], m_kind, "R8");
        chk(irq, m_err & m_en, "R9");
        chk(sync_out, m_sync, "R11");
    endtask

    function automatic bit next_level();
        if (run_left == 0) begin
            level = ~level;
            run_left = $urandom_range(1, 18);
        end
        run_left--;
        return level;
    endfunction

    task automatic sweep_cycles(input int n, input int clr_pct);
        for (int i = 0; i < n; i++) begin
            bit b = next_level();
            bit stb = ($urandom_range(0, 1) == 1);
            bit cw = ($urandom_range(0, 99) < clr_pct);
            step(b, stb, cw, 1'b1, cw ? 11'd1 : 11'd0);
            compare_all();
        end
    endtask

    initial begin
        void'($urandom(7));
        for (int i = 0; i < DEPTH; i++) hist[i] = 1'b0;
        m_err = 0; m_kind = 0; m_sync = 0; m_thr = 0; m_dly = 0; m_mode = 0; m_en = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        rd_addr = 1'b1; #1;
        chk(rd_data, 0, "R1");
        chk(irq, 0, "R1");
        chk(sync_out, 0, "R1");
        rd_addr = 1'b0; #1;
        chk(rd_data, 0, "R1");

        // R2: config readback over several field values
        for (int v = 0; v < 4; v++) begin
            int t = (v * 5 + 3) % 16;
            int d = (v * 11 + 1) % 32;
            write_cfg(t, d, v[0], v[1]);
            rd_addr = 1'b0; #1;
            chk(rd_data, (v[1] << 10) | (v[0] << 9) | (d << 4) | t, "R2");
            rd_addr = 1'b1;
        end

        // Fill the chain with pattern before judging
        write_cfg(0, 0, 1'b0, 1'b0);
        for (int i = 0; i < 70; i++) begin
            step(next_level(), 1'b0, 1'b0, 1'b1, 11'd0);
        end
        rd_addr = 1'b1;

        // Main sweep: every delay and threshold, enabled, manual mode
        for (int d = 0; d < 32; d++) begin
            for (int t = 0; t < 16; t++) begin
                write_cfg(t, d, 1'b0, 1'b1);
                compare_all();
                sweep_cycles(24, 30);
            end
        end

        // R6: sticky bit, write of 0 leaves it, write of 1 clears it
        write_cfg(15, 9, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0, 1'b1, 11'd0);
        step(1'b0, 1'b0, 1'b0, 1'b1, 11'd0);
        repeat (20) step(1'b1, 1'b1, 1'b0, 1'b1, 11'd0);
        chk(rd_data[0], 1, "R6 set");
        repeat (3) step(1'b1, 1'b0, 1'b0, 1'b1, 11'd0);
        chk(rd_data[0], 1, "R6 sticky");
        step(1'b1, 1'b0, 1'b1, 1'b1, 11'd2);
        chk(rd_data[0], 1, "R6 write zero");
        step(1'b1, 1'b0, 1'b1, 1'b1, 11'd1);
        chk(rd_data[0], 0, "R6 clear");
        chk(irq, 0, "R6 irq");

        // R9: enable off, errors never recorded
        for (int d = 0; d < 32; d += 5) begin
            write_cfg(15, d, 1'b0, 1'b0);
            sweep_cycles(30, 10);
        end
        // R10: check mode 1 suspends detection
        for (int d = 0; d < 32; d += 5) begin
            write_cfg(15, d, 1'b1, 1'b1);
            sweep_cycles(30, 10);
        end
        // Back to manual mode with rare clears
        write_cfg(8, 20, 1'b0, 1'b1);
        sweep_cycles(300, 3);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule